// File: doc/BRIEF.md
# Two-Level Translation Table Walker

This block turns a 32-bit virtual address into a physical address by reading descriptors from a two-level translation table in memory. A requester presents a virtual address together with write, instruction-fetch and user-mode flags on a valid/ready handshake. The walker fetches the first-level descriptor and, when that descriptor points to a coarse second-level table, fetches the page entry as well. It then returns one response that holds either the physical address and the granted access level, or a fault.

Descriptor reads go through a port that allows one read in flight: a one-cycle read pulse with an address, answered later by a one-cycle data-valid pulse. The table base, the domain access control word and the memory byte order are static inputs. When a data access faults, the walker captures the virtual address and a status word that holds the domain and the fault class. When an instruction fetch faults, the walker raises a prefetch-abort pulse and leaves both of those registers unchanged. Translation caching is outside this block.

Top module: `mmu_table_walker`

## Requirements
- R1: The first-level descriptor is read at `tbl_base + va[31:20]*4`. Level-1 type 2 (bits [1:0]) is a 1 MB section whose physical address is `{desc[31:20], va[19:0]}`. On every successful response, `rsp_paddr[11:0]` equals `va[11:0]`.
- R2: Level-1 types 0 and 3 end the walk with a translation fault of status 0x5. The domain in the status word is reported as 0, whatever bits [8:5] hold.
- R3: The domain is descriptor bits [8:5], and its 2-bit access value is `dom_ctrl[2*domain +: 2]`. Values 0 and 2 give a domain fault: 0x9 for a section and 0xB for a coarse pointer. Value 3 grants read/write whatever the permission field says. Value 1 applies the permission check.
- R4: Under access value 1 the permission field maps to a level (0 none, 1 read-only, 2 read/write) as follows. ap=0 gives 0. ap=1 gives 2 in privileged mode and 0 in user mode. ap=2 gives 2 in privileged mode and 1 in user mode. ap=3 gives 2. A section takes its permission from level-1 bits [11:10].
- R5: A request succeeds only when the granted level is greater than the write flag. Otherwise it faults with status 0xD for a section or 0xF for a page. A faulting response shows `rsp_access` = 0.
- R6: Level-1 type 1 points to a coarse table, whose entry is read at `{desc[31:10], va[19:12], 2'b00}`. Level-2 type 0 gives a page translation fault of status 0x7.
- R7: Level-2 type 2 is a 4 KB page with physical address `{entry[31:12], va[11:0]}`. Its four permission fields sit at entry bits [5:4], [7:6], [9:8] and [11:10], and `va[11:10]` picks field 0 to 3. `rsp_partial` is 1 exactly when the four fields are not all equal.
- R8: Level-2 type 1 is a 64 KB page with physical address `{entry[31:16], va[15:0]}`. Its permission is field `va[15:14]` of entry bits [11:4] (field 0 at [5:4]). `rsp_partial` is 0.
- R9: Level-2 type 3 is mapped like a 4 KB page, always uses the field at bits [5:4], and reports `rsp_partial` = 1.
- R10: A data fault loads `fault_addr` with the virtual address and `fault_status` with `{24'b0, domain[3:0], status[3:0]}`. Both are visible in the cycle where the response is valid.
- R11: An instruction-fetch fault pulses `prefetch_abort` together with `rsp_valid` and leaves `fault_addr` and `fault_status` unchanged.
- R12: When `big_endian` is 1, every descriptor word is byte-reversed before it is decoded.
- R13: `req_ready` is high only when the walker is idle. At most one read is outstanding, and `mem_rd` is a single-cycle pulse. `rsp_valid` lasts one cycle. After reset, `req_ready`=1, `rsp_valid`=0, `mem_rd`=0, `fault_addr`=0 and `fault_status`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle, request accepted this cycle |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | Access is a write |
| req_ifetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access made in user mode |
| tbl_base | input | 32 | First-level table base (16 KB aligned) |
| dom_ctrl | input | 32 | Sixteen 2-bit domain access values |
| big_endian | input | 1 | Descriptors stored big-endian |
| mem_rd | output | 1 | One-cycle descriptor read pulse |
| mem_addr | output | 32 | Descriptor read address |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |
| rsp_valid | output | 1 | Response valid (one cycle) |
| rsp_fault | output | 1 | Walk ended in a fault |
| rsp_paddr | output | 32 | Physical address |
| rsp_access | output | 2 | Granted level: 0 none, 1 read-only, 2 read/write |
| rsp_partial | output | 1 | Mapping is not a uniform 4 KB-or-larger page |
| prefetch_abort | output | 1 | Instruction-fetch fault pulse |
| fault_addr | output | 32 | Captured data-fault address |
| fault_status | output | 32 | Captured data-fault domain and status |

## Verification
Several corner cases get targeted stimulus. For a level-1 translation fault on a descriptor whose domain bits are nonzero, a design that took the domain from the descriptor would report the wrong status word. Coarse and section domain faults use different codes, so a design that mixed up the two classes would report 0x9 where 0xB belongs. A 4 KB page with mixed permission fields is probed in all four 1 KB quarters, so a design with a wrong field selector would grant the wrong level and a design with a wrong uniformity test would misreport the partial flag. The other cases are the tiny page, which must ignore its selector; the manager domain, which must bypass ap=0; the reserved domain value; an instruction fault, which must leave the fault registers alone; and a byte-swapped section, each of which shows a mis-built design as a wrong address, level or status.

// File: rtl/walk_pkg.sv
// Shared types and constants for the translation table walker.
// Assumes 32-bit addresses and 32-bit descriptors.
package walk_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned DOM_W  = 4;
    localparam int unsigned AP_W   = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_L1   = 2'd1,
        ST_L2   = 2'd2,
        ST_DONE = 2'd3
    } walk_state_t;

    // Fault classes reported in the low nibble of the status word
    localparam logic [3:0] FS_SEC_XLAT = 4'h5;
    localparam logic [3:0] FS_PG_XLAT  = 4'h7;
    localparam logic [3:0] FS_SEC_DOM  = 4'h9;
    localparam logic [3:0] FS_PG_DOM   = 4'hB;
    localparam logic [3:0] FS_SEC_PERM = 4'hD;
    localparam logic [3:0] FS_PG_PERM  = 4'hF;

    // Access levels
    localparam logic [1:0] LVL_NONE = 2'd0;
    localparam logic [1:0] LVL_RO   = 2'd1;
    localparam logic [1:0] LVL_RW   = 2'd2;
endpackage

// File: rtl/walk_byte_order.sv
// Reverses the byte order of a word when big-endian storage is selected.
// Assumes WIDTH is a whole number of bytes.
module walk_byte_order #(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] word_in,
    input  logic             swap,
    output logic [WIDTH-1:0] word_out
);
    localparam int unsigned NBYTES = WIDTH / 8;

    logic [WIDTH-1:0] reversed;

    // One lane per byte: lane b takes byte NBYTES-1-b of the input
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        assign reversed[b*8 +: 8] = word_in[(NBYTES-1-b)*8 +: 8];
    end

    // Select raw or reversed word
    always_comb word_out = swap ? reversed : word_in;
endmodule

// File: rtl/walk_access_check.sv
// Turns a domain access value and a 2-bit permission field into a
// granted level (0 none, 1 read-only, 2 read/write).
// Assumes domain values 0 and 2 are caught as domain faults upstream.
module walk_access_check
    import walk_pkg::*;
(
    input  logic [AP_W-1:0] ap,
    input  logic [1:0]      dom_val,
    input  logic            user,
    output logic [1:0]      level
);
    // Permission table, bypassed for manager domains
    always_comb begin
        level = LVL_NONE;
        if (dom_val == 2'd3) begin
            level = LVL_RW;
        end else if (dom_val == 2'd1) begin
            unique case (ap)
                2'd0: level = LVL_NONE;
                2'd1: level = user ? LVL_NONE : LVL_RW;
                2'd2: level = user ? LVL_RO : LVL_RW;
                default: level = LVL_RW;
            endcase
        end
    end
endmodule

// File: rtl/walk_l2_select.sv
// Decodes a second-level (coarse table) entry: page size, physical
// address, permission field picked by the virtual address, and whether
// the mapping is only partly uniform. Assumes a 32-bit entry.
module walk_l2_select
    import walk_pkg::*;
(
    input  logic [WORD_W-1:0] entry,
    input  logic [WORD_W-1:0] vaddr,
    output logic              xlat_fault,
    output logic [WORD_W-1:0] paddr,
    output logic [AP_W-1:0]   ap,
    output logic              partial
);
    localparam int unsigned NFIELD = 4;

    logic [AP_W-1:0] field [NFIELD];
    logic            uniform;

    // Split the permission nibble pairs out of entry bits [11:4]
    for (genvar f = 0; f < NFIELD; f++) begin : g_field
        assign field[f] = entry[4 + f*AP_W +: AP_W];
    end

    // All four fields equal means the page is uniform
    always_comb uniform = (field[0] == field[1]) && (field[0] == field[2])
                          && (field[0] == field[3]);

    // Page-type decode
    always_comb begin
        xlat_fault = 1'b0;
        paddr      = {entry[31:12], vaddr[11:0]};
        ap         = field[0];
        partial    = 1'b0;
        unique case (entry[1:0])
            2'd0: xlat_fault = 1'b1;
            2'd1: begin
                paddr = {entry[31:16], vaddr[15:0]};
                ap    = field[vaddr[15:14]];
            end
            2'd2: begin
                ap      = field[vaddr[11:10]];
                partial = !uniform;
            end
            default: begin
                ap      = field[0];
                partial = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/mmu_table_walker.sv
// Two-level translation table walker. Accepts one request at a time,
// reads the level-1 descriptor and, for coarse pointers, the level-2
// entry, then issues a single-cycle response. Data faults load the
// fault address/status registers; instruction faults pulse
// prefetch_abort. Assumes the memory answers each mem_rd pulse with
// exactly one mem_rvalid pulse at least one cycle later.
module mmu_table_walker
    import walk_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_vaddr,
    input  logic          req_write,
    input  logic          req_ifetch,
    input  logic          req_user,
    input  logic [AW-1:0] tbl_base,
    input  logic [31:0]   dom_ctrl,
    input  logic          big_endian,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [31:0]   mem_rdata,
    output logic          rsp_valid,
    output logic          rsp_fault,
    output logic [AW-1:0] rsp_paddr,
    output logic [1:0]    rsp_access,
    output logic          rsp_partial,
    output logic          prefetch_abort,
    output logic [AW-1:0] fault_addr,
    output logic [31:0]   fault_status
);
    localparam int unsigned L1_IDX_LSB = 20;

    walk_state_t       state_q;
    logic [AW-1:0]     va_q;
    logic              wr_q, ifetch_q, user_q;
    logic [WORD_W-1:0] l1_q;
    logic              mem_rd_q;
    logic [AW-1:0]     mem_addr_q;

    logic [WORD_W-1:0] desc;
    logic [WORD_W-1:0] dom_src;
    logic [DOM_W-1:0]  dom;
    logic [1:0]        dom_val;
    logic              dom_bad;
    logic [AP_W-1:0]   ap_sel;
    logic [1:0]        level;

    logic              l2_xlat;
    logic [AW-1:0]     l2_pa;
    logic [AP_W-1:0]   l2_ap;
    logic              l2_partial;

    logic              fin;
    logic              go_l2;
    logic              n_fault;
    logic [3:0]        n_fs;
    logic [DOM_W-1:0]  n_dom;
    logic [AW-1:0]     n_pa;
    logic              n_partial;
    logic [AW-1:0]     l2_addr;
    logic [AW-1:0]     l1_addr;
    logic              granted;

    // Byte order normalisation of returned descriptors
    walk_byte_order #(.WIDTH(WORD_W)) u_swap (
        .word_in (mem_rdata),
        .swap    (big_endian),
        .word_out(desc)
    );

    // Second-level entry decode
    walk_l2_select u_l2 (
        .entry     (desc),
        .vaddr     (va_q),
        .xlat_fault(l2_xlat),
        .paddr     (l2_pa),
        .ap        (l2_ap),
        .partial   (l2_partial)
    );

    // Domain comes from the level-1 word, live in L1 and held in L2
    always_comb begin
        dom_src = (state_q == ST_L1) ? desc : l1_q;
        dom     = dom_src[8:5];
        dom_val = dom_ctrl[{dom, 1'b0} +: 2];
        dom_bad = (dom_val == 2'd0) || (dom_val == 2'd2);
        ap_sel  = (state_q == ST_L1) ? desc[11:10] : l2_ap;
    end

    // Shared permission check
    walk_access_check u_acc (
        .ap     (ap_sel),
        .dom_val(dom_val),
        .user   (user_q),
        .level  (level)
    );

    // Address of the level-1 and level-2 reads
    always_comb begin
        l1_addr = {tbl_base[AW-1:14], req_vaddr[AW-1:L1_IDX_LSB], 2'b00};
        l2_addr = {desc[31:10], va_q[19:12], 2'b00};
        granted = level > {1'b0, wr_q};
    end

    // Walk decision on each returned descriptor
    always_comb begin
        fin       = 1'b0;
        go_l2     = 1'b0;
        n_fault   = 1'b0;
        n_fs      = 4'h0;
        n_dom     = dom;
        n_pa      = '0;
        n_partial = 1'b0;
        if (state_q == ST_L1 && mem_rvalid) begin
            unique case (desc[1:0])
                2'd2: begin
                    fin = 1'b1;
                    if (dom_bad) begin
                        n_fault = 1'b1;
                        n_fs    = FS_SEC_DOM;
                    end else if (granted) begin
                        n_pa = {desc[31:20], va_q[19:0]};
                    end else begin
                        n_fault = 1'b1;
                        n_fs    = FS_SEC_PERM;
                    end
                end
                2'd1: begin
                    if (dom_bad) begin
                        fin     = 1'b1;
                        n_fault = 1'b1;
                        n_fs    = FS_PG_DOM;
                    end else begin
                        go_l2 = 1'b1;
                    end
                end
                default: begin
                    fin     = 1'b1;
                    n_fault = 1'b1;
                    n_fs    = FS_SEC_XLAT;
                    n_dom   = '0;
                end
            endcase
        end else if (state_q == ST_L2 && mem_rvalid) begin
            fin = 1'b1;
            if (l2_xlat) begin
                n_fault = 1'b1;
                n_fs    = FS_PG_XLAT;
            end else if (granted) begin
                n_pa      = l2_pa;
                n_partial = l2_partial;
            end else begin
                n_fault = 1'b1;
                n_fs    = FS_PG_PERM;
            end
        end
    end

    // Walk state, request capture and read issue
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            va_q       <= '0;
            wr_q       <= 1'b0;
            ifetch_q   <= 1'b0;
            user_q     <= 1'b0;
            l1_q       <= '0;
            mem_rd_q   <= 1'b0;
            mem_addr_q <= '0;
        end else begin
            mem_rd_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    va_q       <= req_vaddr;
                    wr_q       <= req_write;
                    ifetch_q   <= req_ifetch;
                    user_q     <= req_user;
                    mem_rd_q   <= 1'b1;
                    mem_addr_q <= l1_addr;
                    state_q    <= ST_L1;
                end
                ST_L1: if (go_l2) begin
                    l1_q       <= desc;
                    mem_rd_q   <= 1'b1;
                    mem_addr_q <= l2_addr;
                    state_q    <= ST_L2;
                end else if (fin) begin
                    state_q <= ST_DONE;
                end
                ST_L2: if (fin) state_q <= ST_DONE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Response registers and fault capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_fault    <= 1'b0;
            rsp_paddr    <= '0;
            rsp_access   <= '0;
            rsp_partial  <= 1'b0;
            fault_addr   <= '0;
            fault_status <= '0;
        end else if (fin) begin
            rsp_fault   <= n_fault;
            rsp_paddr   <= n_pa;
            rsp_access  <= n_fault ? LVL_NONE : level;
            rsp_partial <= n_partial;
            if (n_fault && !ifetch_q) begin
                fault_addr   <= va_q;
                fault_status <= {24'b0, n_dom, n_fs};
            end
        end
    end

    // Handshake outputs
    always_comb begin
        req_ready      = (state_q == ST_IDLE);
        rsp_valid      = (state_q == ST_DONE);
        prefetch_abort = rsp_valid && rsp_fault && ifetch_q;
        mem_rd         = mem_rd_q;
        mem_addr       = mem_addr_q;
    end
endmodule

// File: rtl/mmu_table_walker_chk.sv
// Protocol and result checks for mmu_table_walker, bound to every instance.
// Keeps its own copy of the accepted request flags.
module mmu_table_walker_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_vaddr,
    input logic        req_write,
    input logic        req_ifetch,
    input logic        mem_rd,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [31:0] rsp_paddr,
    input logic [1:0]  rsp_access,
    input logic        prefetch_abort,
    input logic [31:0] fault_addr
);
    logic [31:0] c_va;
    logic        c_wr, c_if;

    // Record the request seen at the handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_va <= '0;
            c_wr <= 1'b0;
            c_if <= 1'b0;
        end else if (req_valid && req_ready) begin
            c_va <= req_vaddr;
            c_wr <= req_write;
            c_if <= req_ifetch;
        end
    end

    AST_READ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd); // R13
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R13
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R13
    AST_GRANT_ABOVE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_access > {1'b0, c_wr})); // R5
    AST_FAULT_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_access == 2'd0)); // R5
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_paddr[11:0] == c_va[11:0])); // R1
    AST_PABT_IFETCH_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        prefetch_abort |-> (rsp_valid && rsp_fault && c_if)); // R11
    AST_FAR_DATA_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_addr) |-> (rsp_valid && rsp_fault && !c_if)); // R10
endmodule

bind mmu_table_walker mmu_table_walker_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_write     (req_write),
    .req_ifetch    (req_ifetch),
    .mem_rd        (mem_rd),
    .rsp_valid     (rsp_valid),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .rsp_access    (rsp_access),
    .prefetch_abort(prefetch_abort),
    .fault_addr    (fault_addr)
);

// File: tb/tb_mmu_table_walker.sv
`timescale 1ns/1ps
module tb_mmu_table_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        req_write = 1'b0, req_ifetch = 1'b0, req_user = 1'b0;
    logic [31:0] tbl_base = 32'h0010_0000;
    logic [31:0] dom_ctrl = 32'h0000_008D;
    logic        big_endian = 1'b0;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        rsp_valid, rsp_fault, rsp_partial, prefetch_abort;
    logic [31:0] rsp_paddr, fault_addr, fault_status;
    logic [1:0]  rsp_access;

    int total = 0, bad = 0, done_cnt = 0, cycles = 0;
    logic [31:0] model_far = '0, model_fsr = '0;
    logic [31:0] mem [logic [31:0]];

    typedef struct {
        logic        fault;
        logic [31:0] pa;
        logic [1:0]  acc;
        logic        part;
        logic        pabt;
        logic [31:0] far;
        logic [31:0] fsr;
        string       tag;
    } exp_t;
    exp_t sb [$];

    always #2 clk = ~clk;

    mmu_table_walker dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .req_write(req_write), .req_ifetch(req_ifetch),
        .req_user(req_user), .tbl_base(tbl_base), .dom_ctrl(dom_ctrl),
        .big_endian(big_endian), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .rsp_access(rsp_access),
        .rsp_partial(rsp_partial), .prefetch_abort(prefetch_abort),
        .fault_addr(fault_addr), .fault_status(fault_status)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Memory model: one read at a time, latency 1..3 cycles
    int pend = -1;
    logic [31:0] pend_addr = '0;
    always @(negedge clk) begin
        if (mem_rd) begin
            pend_addr = mem_addr;
            pend = 1 + int'(mem_addr[4:2]) % 3;
        end else if (pend > 0) begin
            pend--;
        end
        if (pend == 0) begin
            mem_rvalid = 1'b1;
            mem_rdata = mem.exists(pend_addr) ? mem[pend_addr] : 32'h0;
            pend = -1;
        end else begin
            mem_rvalid = 1'b0;
        end
    end

    // Monitor: pop expected item on each response and compare
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                check(1'b0, "R13", "unexpected response", 32'h1, 32'h0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                check(rsp_fault == e.fault, e.tag, "fault", 32'(rsp_fault), 32'(e.fault));
                check(prefetch_abort == e.pabt, e.tag, "prefetch_abort",
                      32'(prefetch_abort), 32'(e.pabt));
                check(rsp_access == e.acc, e.tag, "access", 32'(rsp_access), 32'(e.acc));
                if (!e.fault) begin
                    check(rsp_paddr == e.pa, e.tag, "paddr", rsp_paddr, e.pa);
                    check(rsp_partial == e.part, e.tag, "partial",
                          32'(rsp_partial), 32'(e.part));
                end
                check(fault_addr == e.far, e.tag, "fault_addr", fault_addr, e.far);
                check(fault_status == e.fsr, e.tag, "fault_status", fault_status, e.fsr);
            end
            done_cnt++;
        end
    end

    // Driver: push expectation, issue request, wait for its response
    task automatic walk(input logic [31:0] va, input logic wr, input logic ins,
                        input logic usr, input logic flt, input logic [31:0] pa,
                        input logic [1:0] acc, input logic part,
                        input logic [7:0] fsr, input string tag);
        exp_t e;
        int n;
        if (flt && !ins) begin
            model_far = va;
            model_fsr = {24'h0, fsr};
        end
        e.fault = flt; e.pa = pa; e.acc = flt ? 2'd0 : acc; e.part = part;
        e.pabt = flt && ins; e.far = model_far; e.fsr = model_fsr; e.tag = tag;
        sb.push_back(e);
        n = done_cnt;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_write = wr;
        req_ifetch = ins; req_user = usr;
        @(negedge clk);
        req_valid = 1'b0;
        while (done_cnt == n) @(negedge clk);
    endtask

    // Watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            check(1'b0, "R13", "watchdog expired", 32'(cycles), 32'd0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // Level-1 table at 0x0010_0000; dom0 client, dom1 manager, dom2 none, dom3 reserved
        mem[32'h0010_0000] = 32'h0000_0040; // type0, domain bits 2
        mem[32'h0010_0004] = 32'h8000_0C02; // section ap3 dom0
        mem[32'h0010_0008] = 32'h9000_0802; // section ap2 dom0
        mem[32'h0010_000C] = 32'hA000_0402; // section ap1 dom0
        mem[32'h0010_0010] = 32'hB000_0C42; // section dom2
        mem[32'h0010_0014] = 32'hC000_0022; // section ap0 dom1
        mem[32'h0010_0018] = 32'hD000_0C62; // section dom3
        mem[32'h0010_001C] = 32'hE000_0002; // section ap0 dom0
        mem[32'h0010_0020] = 32'h0020_0001; // coarse dom0 -> 0x0020_0000
        mem[32'h0010_0024] = 32'h0020_0041; // coarse dom2
        mem[32'h0010_0028] = 32'h0000_0063; // type3
        mem[32'h0010_002C] = 32'h020C_00F0; // section 0xF00, ap3, stored big-endian
        mem[32'h0020_0004] = 32'h5555_5FF2; // small page, all ap3
        mem[32'h0020_0008] = 32'h6666_61B2; // small page ap0=3 ap1=2 ap2=1 ap3=0
        mem[32'h0020_000C] = 32'h7777_7023; // tiny page ap0=2
        mem[32'h0020_0050] = 32'h8888_00C1; // large page field1=3
        mem[32'h0020_0070] = 32'h9999_03F1; // large page field3=0

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b1, "R13", "reset ready", 32'(req_ready), 32'h1);
        check(rsp_valid == 1'b0 && mem_rd == 1'b0, "R13", "reset valid/rd",
              32'({rsp_valid, mem_rd}), 32'h0);
        check(fault_addr == 0 && fault_status == 0, "R13", "reset fault regs",
              fault_status, 32'h0);

        walk(32'h0012_3456, 1, 0, 0, 0, 32'h8002_3456, 2'd2, 0, 8'h00, "R1");
        walk(32'h0000_0100, 0, 0, 0, 1, 0, 0, 0, 8'h05, "R2");
        walk(32'h00A0_0200, 0, 0, 0, 1, 0, 0, 0, 8'h05, "R2");
        walk(32'h0040_0000, 0, 0, 0, 1, 0, 0, 0, 8'h29, "R3");
        walk(32'h0090_0000, 0, 0, 0, 1, 0, 0, 0, 8'h2B, "R3");
        walk(32'h0060_0010, 0, 0, 0, 1, 0, 0, 0, 8'h39, "R3");
        walk(32'h0050_0040, 1, 0, 1, 0, 32'hC000_0040, 2'd2, 0, 8'h00, "R3");
        walk(32'h0020_0004, 0, 0, 1, 0, 32'h9000_0004, 2'd1, 0, 8'h00, "R4");
        walk(32'h0020_0008, 1, 0, 0, 0, 32'h9000_0008, 2'd2, 0, 8'h00, "R4");
        walk(32'h0030_0000, 0, 0, 0, 0, 32'hA000_0000, 2'd2, 0, 8'h00, "R4");
        walk(32'h0030_0004, 0, 0, 1, 1, 0, 0, 0, 8'h0D, "R4");
        walk(32'h0070_0000, 0, 0, 0, 1, 0, 0, 0, 8'h0D, "R4");
        walk(32'h0020_000C, 1, 0, 1, 1, 0, 0, 0, 8'h0D, "R5");
        walk(32'h0080_0123, 0, 0, 0, 1, 0, 0, 0, 8'h07, "R6");
        walk(32'h0080_1ABC, 1, 0, 0, 0, 32'h5555_5ABC, 2'd2, 0, 8'h00, "R7");
        walk(32'h0080_2000, 1, 0, 1, 0, 32'h6666_6000, 2'd2, 1, 8'h00, "R7");
        walk(32'h0080_2400, 1, 0, 1, 1, 0, 0, 0, 8'h0F, "R7");
        walk(32'h0080_2800, 0, 0, 0, 0, 32'h6666_6800, 2'd2, 1, 8'h00, "R7");
        walk(32'h0080_2C00, 0, 0, 0, 1, 0, 0, 0, 8'h0F, "R5");
        walk(32'h0081_4567, 1, 0, 0, 0, 32'h8888_4567, 2'd2, 0, 8'h00, "R8");
        walk(32'h0081_C123, 0, 0, 0, 1, 0, 0, 0, 8'h0F, "R8");
        walk(32'h0080_3C10, 0, 0, 1, 0, 32'h7777_7C10, 2'd1, 1, 8'h00, "R9");
        walk(32'h0000_0ABC, 0, 1, 0, 1, 0, 0, 0, 8'h05, "R11");
        walk(32'h0080_2C04, 0, 1, 0, 1, 0, 0, 0, 8'h0F, "R11");
        walk(32'h0040_0444, 0, 0, 0, 1, 0, 0, 0, 8'h29, "R10");
        big_endian = 1'b1;
        walk(32'h00B0_0011, 1, 0, 0, 0, 32'hF000_0011, 2'd2, 0, 8'h00, "R12");

        repeat (4) @(negedge clk);
        check(sb.size() == 0, "R13", "pending expectations", 32'(sb.size()), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule